// File: doc/BRIEF.md
# Down-Counting Underflow Interrupt Timer

This block is a down-counter of the kind a processor core uses for periodic timer interrupts. Software loads a count through a write port and can read the live count back at any time. Each pulse on the timebase tick input lowers the count by one. The block raises its interrupt line when the count runs out or is about to run out. It keeps the line raised or drops it according to the signalling mode.

The mode is a static configuration input that is captured while reset is held. In edge mode the interrupt latches and stays pending until the core acknowledges it. In level mode the line follows the top bit of the count, and only a write can remove it. A core with separate supervisor and hypervisor timers instantiates the block twice. Each instance has its own count and its own interrupt output, so the two are independent.

Top module: `countdown_irq_timer`

## Requirements
- R1: Each cycle with `tick_i` high and no write lowers `count_o` by one on the next clock. A tick at zero wraps the count to all ones.
- R2: A write loads `wr_data_i` into `count_o` on the next clock. A tick in the same cycle is discarded, so the write wins.
- R3: A tick taken while the count is 2, 1 or 0 sets `irq_o` on the next clock, in both modes.
- R4: A write of a value below 3 sets `irq_o` on the next clock, in both modes.
- R5: In level mode (`mode_level_i` = 1 at reset), `irq_o` is high in every cycle in which bit W-1 of `count_o` is 1. This includes the cycles after reset and after a write that sets that bit.
- R6: In level mode, a write of a value of 3 or more with bit W-1 clear lowers `irq_o` on the next clock.
- R7: In level mode, `ack_i` has no effect on `irq_o`.
- R8: In edge mode (`mode_level_i` = 0 at reset), a write with bit W-1 set raises `irq_o` only if bit W-1 of the old count was clear. A write that leaves the bit set raises nothing.
- R9: In edge mode, `ack_i` clears a pending `irq_o` on the next clock. A raise event in the same cycle takes priority and keeps the line high.
- R10: While `rst` is high, the count is set to all ones and `mode_level_i` is captured. `irq_o` resets low in edge mode and high in level mode.
- R11: In edge mode, ticks from counts above 2, including ticks while bit W-1 is set, leave `irq_o` unchanged. Writes with bit W-1 clear also leave `irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_level_i | input | 1 | Signalling mode, captured during reset: 1 = level, 0 = edge |
| tick_i | input | 1 | Timebase tick, one decrement per high cycle |
| wr_en_i | input | 1 | Count write strobe |
| wr_data_i | input | W (32) | Value to load |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| count_o | output | W (32) | Current count, registered |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The bench tests the wrap from 0 to all ones. A design that re-armed on the top bit during plain counting would raise a second, spurious interrupt there. It writes a value with the top bit set over an old count that already had it set, which separates a true 0-to-1 detector from a plain level check. It applies an acknowledge in the same cycle as a tick from 2. A design that let the clear win would lose that expiry. It also applies an acknowledge in level mode, where a design that cleared the line would drop an interrupt that the count still demands. The bench resets in both modes. A design that raised the line at reset in edge mode, or held it low at reset in level mode, is reported.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } cdt_mode_e;
endpackage

// File: rtl/cdt_count_reg.sv
module cdt_count_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_nxt
);
  localparam logic [W-1:0] RELOAD = '1;
  localparam logic [W-1:0] ONE    = W'(1);

  // a write overrides a simultaneous tick
  always_comb begin
    if (wr_en_i)     count_nxt = wr_data_i;
    else if (tick_i) count_nxt = count_q - ONE;
    else             count_nxt = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= RELOAD;
    else     count_q <= count_nxt;
  end
endmodule

// File: rtl/cdt_event_detect.sv
module cdt_event_detect
  import cdt_pkg::*;
#(
  parameter int W          = 32,
  parameter int NEAR_LIMIT = 3
) (
  input  cdt_mode_e    mode_i,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] count_q,
  input  logic [W-1:0] count_nxt,
  output logic         raise_o,
  output logic         drop_o
);
  localparam int           TOP    = W - 1;
  localparam logic [W-1:0] NEAR_V = W'(NEAR_LIMIT);

  logic wr_near, wr_top_rise, tick_expire, level_hold;

  always_comb begin
    wr_near     = wr_en_i && (wr_data_i < NEAR_V);
    wr_top_rise = wr_en_i && wr_data_i[TOP] && !count_q[TOP];
    tick_expire = !wr_en_i && tick_i && (count_q < NEAR_V);
    level_hold  = (mode_i == MODE_LEVEL) && count_nxt[TOP];
    raise_o     = wr_near || tick_expire || level_hold ||
                  ((mode_i == MODE_EDGE) && wr_top_rise);
    drop_o      = (mode_i == MODE_LEVEL) && wr_en_i && !wr_data_i[TOP];
  end
endmodule

// File: rtl/cdt_irq_ctrl.sv
module cdt_irq_ctrl
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_level_i,
  input  logic      raise_i,
  input  logic      drop_i,
  input  logic      ack_i,
  output cdt_mode_e mode_q,
  output logic      irq_q
);
  logic clear;

  always_comb clear = drop_i || ((mode_q == MODE_EDGE) && ack_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_level_i ? MODE_LEVEL : MODE_EDGE;
      irq_q  <= mode_level_i;  // reload value has top bit set
    end else if (raise_i) begin
      irq_q <= 1'b1;
    end else if (clear) begin
      irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer
  import cdt_pkg::*;
#(
  parameter int W          = 32,
  parameter int NEAR_LIMIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_level_i,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         ack_i,
  output logic [W-1:0] count_o,
  output logic         irq_o
);
  logic [W-1:0] count_q, count_nxt;
  logic         raise, drop;
  cdt_mode_e    mode_level_q;

  cdt_count_reg #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .count_q(count_q), .count_nxt(count_nxt)
  );

  cdt_event_detect #(.W(W), .NEAR_LIMIT(NEAR_LIMIT)) u_evt (
    .mode_i(mode_level_q), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .count_q(count_q), .count_nxt(count_nxt),
    .raise_o(raise), .drop_o(drop)
  );

  cdt_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .mode_level_i(mode_level_i), .raise_i(raise),
    .drop_i(drop), .ack_i(ack_i), .mode_q(mode_level_q), .irq_q(irq_o)
  );

  assign count_o = count_q;
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_level_i,
  input logic         mode_q,
  input logic         tick_i,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic         ack_i,
  input logic [W-1:0] count_o,
  input logic         irq_o
);
  localparam int TOP = W - 1;

  assert_decrement_R1: assert property (@(posedge clk) disable iff (rst)
    tick_i && !wr_en_i |=> count_o == $past(count_o) - W'(1));

  assert_write_wins_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> count_o == $past(wr_data_i));

  assert_expiry_R3: assert property (@(posedge clk) disable iff (rst)
    tick_i && !wr_en_i && count_o < W'(3) |=> irq_o);

  assert_small_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en_i && wr_data_i < W'(3) |=> irq_o);

  assert_level_follows_R5: assert property (@(posedge clk) disable iff (rst)
    mode_q && count_o[TOP] |-> irq_o);

  assert_level_drop_R6: assert property (@(posedge clk) disable iff (rst)
    mode_q && wr_en_i && !wr_data_i[TOP] && wr_data_i >= W'(3) |=> !irq_o);

  assert_level_ack_R7: assert property (@(posedge clk) disable iff (rst)
    mode_q && ack_i && !wr_en_i && irq_o |=> irq_o);

  assert_edge_rise_R8: assert property (@(posedge clk) disable iff (rst)
    !mode_q && wr_en_i && wr_data_i[TOP] && !count_o[TOP] |=> irq_o);

  assert_edge_ack_R9: assert property (@(posedge clk) disable iff (rst)
    !mode_q && ack_i && !wr_en_i && !(tick_i && count_o < W'(3)) |=> !irq_o);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst && !mode_level_i |=> !irq_o && count_o == '1);
endmodule

bind countdown_irq_timer cdt_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_level_i(mode_level_i), .mode_q(mode_level_q),
  .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
  .count_o(count_o), .irq_o(irq_o)
);

// File: tb/countdown_irq_timer_test.sv
module countdown_irq_timer_test;
  localparam int W = 32;
  // vector: op[2:0] data[31:0] exp_count[31:0] exp_irq
  // op: 0 idle, 1 tick, 2 write, 3 ack, 4 write+tick, 5 ack+tick
  localparam int NV = 21;
  localparam logic [67:0] VEC [NV] = '{
    {3'd2, 32'd5,          32'd5,          1'b0}, // R2
    {3'd1, 32'd0,          32'd4,          1'b0}, // R1
    {3'd1, 32'd0,          32'd3,          1'b0}, // R11
    {3'd1, 32'd0,          32'd2,          1'b0}, // R11
    {3'd1, 32'd0,          32'd1,          1'b1}, // R3
    {3'd3, 32'd0,          32'd1,          1'b0}, // R9
    {3'd1, 32'd0,          32'd0,          1'b1}, // R3
    {3'd3, 32'd0,          32'd0,          1'b0}, // R9
    {3'd1, 32'd0,          32'hFFFFFFFF,   1'b1}, // R1 R3 wrap
    {3'd3, 32'd0,          32'hFFFFFFFF,   1'b0}, // R9
    {3'd1, 32'd0,          32'hFFFFFFFE,   1'b0}, // R11
    {3'd2, 32'h80000000,   32'h80000000,   1'b0}, // R8 no rise
    {3'd2, 32'd10,         32'd10,         1'b0}, // R11
    {3'd2, 32'h80000000,   32'h80000000,   1'b1}, // R8 rise
    {3'd3, 32'd0,          32'h80000000,   1'b0}, // R9
    {3'd2, 32'd2,          32'd2,          1'b1}, // R4
    {3'd3, 32'd0,          32'd2,          1'b0}, // R9
    {3'd5, 32'd0,          32'd1,          1'b1}, // R9 raise beats ack
    {3'd4, 32'd100,        32'd100,        1'b1}, // R2 write wins
    {3'd3, 32'd0,          32'd100,        1'b0}, // R9
    {3'd2, 32'd0,          32'd0,          1'b1}  // R4
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_level_i = 1'b0;
  logic         tick_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         ack_i = 1'b0;
  logic [W-1:0] count_o;
  logic         irq_o;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  countdown_irq_timer #(.W(W)) uut (
    .clk(clk), .rst(rst), .mode_level_i(mode_level_i), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
    .count_o(count_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [W-1:0] ec, input logic ei);
    compared++;
    if (count_o !== ec || irq_o !== ei) begin
      mismatched++;
      $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
               req, count_o, irq_o, ec, ei);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [W-1:0] data);
    @(negedge clk);
    tick_i    = (op == 3'd1 || op == 3'd4 || op == 3'd5);
    wr_en_i   = (op == 3'd2 || op == 3'd4);
    ack_i     = (op == 3'd3 || op == 3'd5);
    wr_data_i = data;
    @(posedge clk);
    #2;
    tick_i = 1'b0; wr_en_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst = 1'b1; mode_level_i = lvl;
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b0;
  endtask

  initial begin
    do_reset(1'b0);
    check("R10 edge reset", 32'hFFFFFFFF, 1'b0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][67:65], VEC[i][64:33]);
      check($sformatf("R1-table vector %0d", i), VEC[i][32:1], VEC[i][0]);
    end
    step(3'd2, 32'd1);
    check("R4 before reset", 32'd1, 1'b1);
    do_reset(1'b0);
    check("R10 edge reset clears pending", 32'hFFFFFFFF, 1'b0);

    do_reset(1'b1);
    check("R10 R5 level reset", 32'hFFFFFFFF, 1'b1);
    step(3'd3, 0);  check("R7 level ack ignored", 32'hFFFFFFFF, 1'b1);
    step(3'd2, 5);  check("R6 level write clear", 32'd5, 1'b0);
    step(3'd1, 0);  check("R1 level tick", 32'd4, 1'b0);
    step(3'd1, 0);  check("R1 level tick", 32'd3, 1'b0);
    step(3'd1, 0);  check("R3 level from 3", 32'd2, 1'b0);
    step(3'd1, 0);  check("R3 level expiry", 32'd1, 1'b1);
    step(3'd3, 0);  check("R7 level ack after expiry", 32'd1, 1'b1);
    step(3'd2, 7);  check("R6 level write drops", 32'd7, 1'b0);
    step(3'd2, 32'h80000005); check("R5 level top bit write", 32'h80000005, 1'b1);
    step(3'd1, 0);  check("R5 level holds while counting", 32'h80000004, 1'b1);
    step(3'd2, 50); check("R6 level drop again", 32'd50, 1'b0);
    step(3'd2, 1);  check("R4 level small write", 32'd1, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule